// File: doc/BRIEF.md
# Stage-2 IPA Invalidation TLB

This block is a small fully associative translation cache that holds stage-2 entries, together with the engine that carries out the command "invalidate by intermediate physical address, stage 2, last level". A command carries a 64-bit operand word. The caller also supplies the current VMID, the current security state, the exception level, and the configuration bits that gate the command: EL2 enabled, the nested-virtualization trap bit, secure-EL2 support and 52-bit addressing.

The engine first decides whether the command runs. The outcome is one of four: it executes, it is a no-op, it is undefined, or it is trapped to EL2. When it executes, the engine decodes the address, the IPA-space select bit and the level hint. It compares the command against all entries at once and clears every entry that matches. Each entry is compared at the size of its own block, so a block mapping is removed by any address inside it.

A fill port loads entries into slots in rotating order. A lookup port reports whether any valid entry covers a given page for a given VMID and IPA space. The lookup port is how the contents of the cache are observed.

Top module: `s2_ipa_inval_tlb`

## Requirements
- R1: After reset no entry is valid (lk_hit is 0 for every lookup), done_o is 0 and cmd_ready is 1.
- R2: Each fill writes one slot and marks it valid. Slots are written in rotating order 0,1,...,N-1,0, so fill number N+1 replaces the entry written by fill 1.
- R3: An executed command clears an entry only if all of these hold: the entry is valid, it is a stage-2-only entry, it is a last-level entry, its VMID equals cmd_vmid, and its IPA space equals the target space.
- R4: The address compare ignores the entry's low page-number bits that fall inside its block. The page number is IPA[51:12]. The number of ignored bits is 0/9/18 for a 4KB granule at levels 3/2/1, 2/13 for a 16KB granule at levels 3/2, and 4/17/30 for a 64KB granule at levels 3/2/1. Granule codes are 01=4KB, 10=16KB, 11=64KB.
- R5: The operand fields are: bit 63 selects the IPA space (1 = Non-secure), bits 47:44 are the level hint, bits 39:36 hold IPA[51:48], and bits 35:0 hold IPA[47:12]. From Non-secure state (cmd_nonsec=1) bit 63 is ignored and the target is Non-secure. From Secure state the target is bit 63 when sec_el2_en=1, and Secure otherwise.
- R6: A valid hint has hint[3:2] equal to the granule code and hint[1:0] equal to the level (01=1, 10=2, 11=3). A command with a valid hint clears only entries whose stored granule and level are equal to the hint.
- R7: These hint values are treated exactly as "no hint", which matches any granule and level: hint[3:2]=00, hint[1:0]=00, and granule 10 with level 01.
- R8: Operand bits 39:36 take part in the compare only when lpa52_en=1 and the entry's granule is 64KB. In all other cases they are replaced by zero.
- R9: The outcome depends on cmd_el (0..3) as follows. EL0 gives undefined. EL1 gives a trap with trap_ec_o=0x18 when el2_en and nv_en are both 1, and undefined otherwise. EL2 executes. EL3 executes when el2_en=1, and is a no-op otherwise. Only an executed command changes any entry.
- R10: The cycle after a command is accepted (cmd_valid and cmd_ready), done_o is 1 for one cycle and result_o holds the outcome: 0 = execute, 1 = no-op, 2 = undefined, 3 = trap. trap_ec_o is 0x18 on a trap and 0 otherwise.
- R11: cmd_ready is 0 in any cycle where fill_valid is 1. The fill is written and the command waits, then it is accepted in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Write one entry this cycle |
| fill_vmid | input | 16 | VMID of the new entry |
| fill_ns | input | 1 | IPA space of the new entry (1 = Non-secure) |
| fill_s2only | input | 1 | Entry is stage-2 only |
| fill_last | input | 1 | Entry is from the last walk level |
| fill_gran | input | 2 | Granule code of the new entry |
| fill_lvl | input | 2 | Leaf level of the new entry |
| fill_page | input | 40 | IPA[51:12] of the new entry |
| cmd_valid | input | 1 | Invalidate command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 64 | Command operand word |
| cmd_vmid | input | 16 | Current VMID |
| cmd_el | input | 2 | Exception level issuing the command |
| cmd_nonsec | input | 1 | Issuing state is Non-secure |
| el2_en | input | 1 | EL2 enabled in the current state |
| nv_en | input | 1 | Nested-virtualization trap bit |
| sec_el2_en | input | 1 | Secure EL2 supported and enabled |
| lpa52_en | input | 1 | 52-bit IPA addressing in use |
| done_o | output | 1 | Command completion pulse |
| result_o | output | 2 | Outcome code of the completed command |
| trap_ec_o | output | 6 | Syndrome class when trapped |
| lk_vmid | input | 16 | Lookup VMID |
| lk_ns | input | 1 | Lookup IPA space |
| lk_page | input | 40 | Lookup page number IPA[51:12] |
| lk_hit | output | 1 | Some valid entry covers the lookup page |

## Verification
The bench targets the compare corners. Block entries are hit by addresses away from their base: a design that compares full page numbers leaves them cached. Entries that are not last level, or not stage-2 only, are kept on the same address: a design that drops those qualifiers removes them. Hints that name the wrong level must spare an entry, while reserved hints must still remove it: a design with the wrong fallback keeps the entry or over-clears. IPA[51:48] must be ignored unless 52-bit addressing meets a 64KB entry. Bit 63 must be ignored from Non-secure state. Each privilege outcome is checked for its result code and for not touching entries. A fill collides with a command, and the 17th fill wraps to the first slot, which exposes a wrong priority or a wrong rotating pointer.

// File: rtl/s2inv_pkg.sv
package s2inv_pkg;

    localparam int VMID_W = 16;
    localparam int PAGE_W = 40;
    localparam logic [5:0] TRAP_EC = 6'h18;

    typedef enum logic [1:0] {
        RES_EXEC  = 2'd0,
        RES_NOP   = 2'd1,
        RES_UNDEF = 2'd2,
        RES_TRAP  = 2'd3
    } res_e;

    typedef struct packed {
        logic              vld;
        logic [VMID_W-1:0] vmid;
        logic              ns;
        logic              s2only;
        logic              last;
        logic [1:0]        gran;
        logic [1:0]        lvl;
        logic [PAGE_W-1:0] page;
    } tlb_ent_t;

    // number of page-number bits covered by one block of the given size
    function automatic logic [4:0] blk_bits(input logic [1:0] gran, input logic [1:0] lvl);
        logic [4:0] r;
        r = 5'd0;
        unique case (gran)
            2'b01: begin
                unique case (lvl)
                    2'd3: r = 5'd0;
                    2'd2: r = 5'd9;
                    2'd1: r = 5'd18;
                    default: r = 5'd27;
                endcase
            end
            2'b10: begin
                unique case (lvl)
                    2'd3: r = 5'd2;
                    2'd2: r = 5'd13;
                    default: r = 5'd24;
                endcase
            end
            2'b11: begin
                unique case (lvl)
                    2'd3: r = 5'd4;
                    2'd2: r = 5'd17;
                    default: r = 5'd30;
                endcase
            end
            default: r = 5'd0;
        endcase
        return r;
    endfunction

    function automatic logic page_eq(input logic [PAGE_W-1:0] a, input logic [PAGE_W-1:0] b,
                                     input logic [4:0] bits);
        logic [PAGE_W-1:0] keep;
        keep = ~((PAGE_W'(1) << bits) - PAGE_W'(1));
        return ((a ^ b) & keep) == '0;
    endfunction

endpackage

// File: rtl/s2inv_decode.sv
module s2inv_decode
    import s2inv_pkg::*;
(
    input  logic [63:0] op,
    input  logic [1:0]  el,
    input  logic        nonsec,
    input  logic        el2_en,
    input  logic        nv_en,
    input  logic        sec_el2_en,
    output res_e        res,
    output logic        tgt_ns,
    output logic        hint_on,
    output logic [1:0]  hint_gran,
    output logic [1:0]  hint_lvl,
    output logic [3:0]  ipa_hi,
    output logic [35:0] ipa_lo
);

    always_comb begin
        unique case (el)
            2'd0:    res = RES_UNDEF;
            2'd1:    res = (el2_en && nv_en) ? RES_TRAP : RES_UNDEF;
            2'd2:    res = RES_EXEC;
            default: res = el2_en ? RES_EXEC : RES_NOP;
        endcase
    end

    // IPA space: non-secure callers always hit the non-secure space
    always_comb begin
        if (nonsec)          tgt_ns = 1'b1;
        else if (sec_el2_en) tgt_ns = op[63];
        else                 tgt_ns = 1'b0;
    end

    assign hint_gran = op[47:46];
    assign hint_lvl  = op[45:44];
    assign hint_on   = (hint_gran != 2'b00) && (hint_lvl != 2'b00)
                       && !((hint_gran == 2'b10) && (hint_lvl == 2'b01));
    assign ipa_hi    = op[39:36];
    assign ipa_lo    = op[35:0];

endmodule

// File: rtl/s2inv_match.sv
module s2inv_match
    import s2inv_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VMID_W-1:0] vmid,
    input  logic              tgt_ns,
    input  logic              hint_on,
    input  logic [1:0]        hint_gran,
    input  logic [1:0]        hint_lvl,
    input  logic [3:0]        ipa_hi,
    input  logic [35:0]       ipa_lo,
    input  logic              lpa52_en,
    output logic              hit
);

    logic [PAGE_W-1:0] cmd_page;
    logic              qual_ok;
    logic              hint_ok;

    always_comb begin
        cmd_page = {((lpa52_en && ent.gran == 2'b11) ? ipa_hi : 4'b0000), ipa_lo};
        qual_ok  = ent.vld && ent.s2only && ent.last && (ent.vmid == vmid) && (ent.ns == tgt_ns);
        hint_ok  = !hint_on || ((ent.gran == hint_gran) && (ent.lvl == hint_lvl));
        hit      = qual_ok && hint_ok && page_eq(ent.page, cmd_page, blk_bits(ent.gran, ent.lvl));
    end

endmodule

// File: rtl/s2_ipa_inval_tlb.sv
module s2_ipa_inval_tlb
    import s2inv_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic              fill_ns,
    input  logic              fill_s2only,
    input  logic              fill_last,
    input  logic [1:0]        fill_gran,
    input  logic [1:0]        fill_lvl,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [63:0]       cmd_op,
    input  logic [VMID_W-1:0] cmd_vmid,
    input  logic [1:0]        cmd_el,
    input  logic              cmd_nonsec,
    input  logic              el2_en,
    input  logic              nv_en,
    input  logic              sec_el2_en,
    input  logic              lpa52_en,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic [5:0]        trap_ec_o,
    input  logic [VMID_W-1:0] lk_vmid,
    input  logic              lk_ns,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_hit
);

    localparam int PTR_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_ENT - 1);

    typedef struct packed {
        tlb_ent_t [NUM_ENT-1:0] ent;
        logic [PTR_W-1:0]       ptr;
        logic                   done;
        res_e                   res;
        logic [5:0]             ec;
    } st_t;

    st_t st_d, st_q;

    res_e        dec_res;
    logic        dec_ns, dec_hint_on;
    logic [1:0]  dec_hgran, dec_hlvl;
    logic [3:0]  dec_hi;
    logic [35:0] dec_lo;
    logic        cmd_acc;

    logic [NUM_ENT-1:0] inv_hit;
    logic [NUM_ENT-1:0] lk_hit_v;
    logic [NUM_ENT-1:0] vld_q;

    s2inv_decode u_dec (
        .op         (cmd_op),
        .el         (cmd_el),
        .nonsec     (cmd_nonsec),
        .el2_en     (el2_en),
        .nv_en      (nv_en),
        .sec_el2_en (sec_el2_en),
        .res        (dec_res),
        .tgt_ns     (dec_ns),
        .hint_on    (dec_hint_on),
        .hint_gran  (dec_hgran),
        .hint_lvl   (dec_hlvl),
        .ipa_hi     (dec_hi),
        .ipa_lo     (dec_lo)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        s2inv_match u_m (
            .ent       (st_q.ent[i]),
            .vmid      (cmd_vmid),
            .tgt_ns    (dec_ns),
            .hint_on   (dec_hint_on),
            .hint_gran (dec_hgran),
            .hint_lvl  (dec_hlvl),
            .ipa_hi    (dec_hi),
            .ipa_lo    (dec_lo),
            .lpa52_en  (lpa52_en),
            .hit       (inv_hit[i])
        );
        assign lk_hit_v[i] = st_q.ent[i].vld && (st_q.ent[i].vmid == lk_vmid)
                             && (st_q.ent[i].ns == lk_ns)
                             && page_eq(st_q.ent[i].page, lk_page,
                                        blk_bits(st_q.ent[i].gran, st_q.ent[i].lvl));
        assign vld_q[i] = st_q.ent[i].vld;
    end

    // a fill in the same cycle takes the slot; the command waits
    assign cmd_ready = !fill_valid;
    assign cmd_acc   = cmd_valid && cmd_ready;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (fill_valid) begin
            st_d.ent[st_q.ptr].vld    = 1'b1;
            st_d.ent[st_q.ptr].vmid   = fill_vmid;
            st_d.ent[st_q.ptr].ns     = fill_ns;
            st_d.ent[st_q.ptr].s2only = fill_s2only;
            st_d.ent[st_q.ptr].last   = fill_last;
            st_d.ent[st_q.ptr].gran   = fill_gran;
            st_d.ent[st_q.ptr].lvl    = fill_lvl;
            st_d.ent[st_q.ptr].page   = fill_page;
            st_d.ptr = (st_q.ptr == PTR_LAST) ? '0 : st_q.ptr + PTR_W'(1);
        end
        if (cmd_acc) begin
            st_d.done = 1'b1;
            st_d.res  = dec_res;
            st_d.ec   = (dec_res == RES_TRAP) ? TRAP_EC : 6'd0;
            if (dec_res == RES_EXEC) begin
                for (int i = 0; i < NUM_ENT; i++) begin
                    if (inv_hit[i]) st_d.ent[i].vld = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o    = st_q.done;
    assign result_o  = st_q.res;
    assign trap_ec_o = st_q.ec;
    assign lk_hit    = |lk_hit_v;

    a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> vld_q[$past(st_q.ptr)]);

    a_r9_non_exec_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_acc && dec_res != RES_EXEC) |=> (vld_q == $past(vld_q)));

    a_r10_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_acc |=> done_o);

    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_acc |=> !done_o);

    a_r11_fill_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && fill_valid) |=> !done_o);

    a_r9_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((result_o == RES_TRAP) == (trap_ec_o == TRAP_EC)));

endmodule

// File: tb/s2_ipa_inval_tlb_tb_top.sv
`timescale 1ns/1ps
module s2_ipa_inval_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_vmid = '0;
    logic        fill_ns = 1'b0, fill_s2only = 1'b0, fill_last = 1'b0;
    logic [1:0]  fill_gran = '0, fill_lvl = '0;
    logic [39:0] fill_page = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_op = '0;
    logic [15:0] cmd_vmid = '0;
    logic [1:0]  cmd_el = 2'd2;
    logic        cmd_nonsec = 1'b1, el2_en = 1'b1, nv_en = 1'b0, sec_el2_en = 1'b0, lpa52_en = 1'b0;
    logic        done_o;
    logic [1:0]  result_o;
    logic [5:0]  trap_ec_o;
    logic [15:0] lk_vmid = '0;
    logic        lk_ns = 1'b0;
    logic [39:0] lk_page = '0;
    logic        lk_hit;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    s2_ipa_inval_tlb dut_i (.*);

    // behavioural model of the cache contents
    bit          m_vld[16];
    logic [15:0] m_vmid[16];
    bit          m_ns[16], m_s2[16], m_last[16];
    int          m_gran[16], m_lvl[16];
    logic [39:0] m_page[16];
    int          m_ptr = 0;

    function automatic int shift_of(int g, int l);
        int gb;
        gb = 10 + 2 * g;
        return gb + (3 - l) * (gb - 3) - 12;
    endfunction

    function automatic bit model_lookup();
        for (int i = 0; i < 16; i++)
            if (m_vld[i] && m_vmid[i] == lk_vmid && m_ns[i] == lk_ns &&
                (m_page[i] >> shift_of(m_gran[i], m_lvl[i])) == (lk_page >> shift_of(m_gran[i], m_lvl[i])))
                return 1;
        return 0;
    endfunction

    function automatic int model_result(int el, bit e2, bit nv);
        if (el == 0) return 2;
        if (el == 1) return (e2 && nv) ? 3 : 2;
        if (el == 2) return 0;
        return e2 ? 0 : 1;
    endfunction

    task automatic model_inval(logic [63:0] op, logic [15:0] vm, bit nsst, bit sece, bit lpa);
        bit tns, hon;
        int hg, hl, sh;
        logic [39:0] cp;
        tns = nsst ? 1'b1 : (sece ? op[63] : 1'b0);
        hg = int'(op[47:46]);
        hl = int'(op[45:44]);
        hon = (hg != 0) && (hl != 0) && !(hg == 2 && hl == 1);
        for (int i = 0; i < 16; i++) begin
            cp = {((lpa && m_gran[i] == 3) ? op[39:36] : 4'h0), op[35:0]};
            sh = shift_of(m_gran[i], m_lvl[i]);
            if (m_vld[i] && m_s2[i] && m_last[i] && m_vmid[i] == vm && m_ns[i] == tns &&
                (!hon || (hg == m_gran[i] && hl == m_lvl[i])) && (m_page[i] >> sh) == (cp >> sh))
                m_vld[i] = 0;
        end
    endtask

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // lookup compared against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) chk(lk_hit == model_lookup(), "R4 lookup vs model", lk_hit, model_lookup());
    end

    task automatic fill(logic [15:0] vm, bit ns, bit s2, bit last, int g, int l, logic [39:0] pg);
        @(posedge clk); #1;
        fill_valid = 1; fill_vmid = vm; fill_ns = ns; fill_s2only = s2; fill_last = last;
        fill_gran = 2'(g); fill_lvl = 2'(l); fill_page = pg;
        @(posedge clk); #1;
        fill_valid = 0;
        m_vld[m_ptr] = 1; m_vmid[m_ptr] = vm; m_ns[m_ptr] = ns; m_s2[m_ptr] = s2; m_last[m_ptr] = last;
        m_gran[m_ptr] = g; m_lvl[m_ptr] = l; m_page[m_ptr] = pg;
        m_ptr = (m_ptr + 1) % 16;
    endtask

    function automatic logic [63:0] mkop(bit ns, logic [3:0] ttl, logic [39:0] pg);
        return {ns, 15'b0, ttl, 4'b0, pg};
    endfunction

    task automatic cmd(string req, logic [63:0] op, logic [15:0] vm, int el, bit nsst,
                       bit e2, bit nv, bit sece, bit lpa);
        int er;
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_vmid = vm; cmd_el = 2'(el); cmd_nonsec = nsst;
        el2_en = e2; nv_en = nv; sec_el2_en = sece; lpa52_en = lpa;
        @(posedge clk); #1;
        cmd_valid = 0;
        er = model_result(el, e2, nv);
        if (er == 0) model_inval(op, vm, nsst, sece, lpa);
        @(negedge clk);
        chk(done_o == 1, {req, " R10 done"}, done_o, 1);
        chk(result_o == 2'(er), {req, " R9 result"}, result_o, er);
        chk(trap_ec_o == ((er == 3) ? 6'h18 : 6'h0), {req, " R10 ec"}, trap_ec_o, (er == 3) ? 24 : 0);
        @(negedge clk);
        chk(done_o == 0, {req, " R10 one-cycle pulse"}, done_o, 0);
    endtask

    task automatic look(string req, logic [15:0] vm, bit ns, logic [39:0] pg, bit exp);
        @(posedge clk); #1;
        lk_vmid = vm; lk_ns = ns; lk_page = pg;
        @(negedge clk);
        chk(lk_hit == exp, req, lk_hit, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(lk_hit == 0, "R1 empty after reset", lk_hit, 0);
        chk(done_o == 0, "R1 done low", done_o, 0);
        chk(cmd_ready == 1, "R1 ready", cmd_ready, 1);

        fill(16'd5, 1, 1, 1, 1, 3, 40'h10);          // 0 basic
        fill(16'd5, 1, 0, 1, 1, 3, 40'h20);          // 1 not stage-2 only
        fill(16'd5, 1, 1, 0, 1, 3, 40'h30);          // 2 not last level
        fill(16'd6, 1, 1, 1, 1, 3, 40'h40);          // 3 other vmid
        fill(16'd5, 0, 1, 1, 1, 3, 40'h50);          // 4 secure space
        fill(16'd5, 1, 1, 1, 1, 3, 40'h60);          // 5
        fill(16'd5, 1, 1, 1, 1, 2, 40'h40000);       // 6 4KB L2 block
        fill(16'd5, 1, 1, 1, 2, 3, 40'h80004);       // 7 16KB L3
        fill(16'd5, 1, 1, 1, 3, 2, 40'h100000);      // 8 64KB L2
        fill(16'd5, 1, 1, 1, 3, 3, 40'h3000000100);  // 9 64KB L3 with high bits
        fill(16'd5, 1, 1, 1, 1, 3, 40'h70);          // 10 hint target
        fill(16'd5, 1, 1, 1, 1, 2, 40'h400);         // 11 reserved hint target
        fill(16'd5, 1, 1, 1, 1, 3, 40'h900);         // 12
        fill(16'd5, 1, 1, 1, 1, 3, 40'h910);         // 13 privilege target
        fill(16'd5, 1, 1, 1, 1, 3, 40'h920);         // 14
        fill(16'd5, 1, 1, 1, 1, 3, 40'h930);         // 15
        look("R2 slot 15 filled", 16'd5, 1, 40'h930, 1);

        cmd("R3 basic", mkop(0, 4'h0, 40'h10), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R3 basic entry cleared", 16'd5, 1, 40'h10, 0);
        cmd("R3 s2only", mkop(0, 4'h0, 40'h20), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R3 non stage-2-only kept", 16'd5, 1, 40'h20, 1);
        cmd("R3 last", mkop(0, 4'h0, 40'h30), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R3 non-last kept", 16'd5, 1, 40'h30, 1);
        cmd("R3 vmid", mkop(0, 4'h0, 40'h40), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R3 other vmid kept", 16'd6, 1, 40'h40, 1);
        cmd("R3 vmid match", mkop(0, 4'h0, 40'h40), 16'd6, 2, 1, 1, 0, 0, 0);
        look("R3 vmid match cleared", 16'd6, 1, 40'h40, 0);

        cmd("R5 ns ignored", mkop(0, 4'h0, 40'h50), 16'd5, 2, 1, 1, 0, 1, 0);
        look("R5 nonsec caller spares secure", 16'd5, 0, 40'h50, 1);
        cmd("R5 secure state", mkop(1, 4'h0, 40'h50), 16'd5, 2, 0, 1, 0, 0, 0);
        look("R5 no sec-EL2 follows state", 16'd5, 0, 40'h50, 0);
        cmd("R5 sec el2 ns", mkop(1, 4'h0, 40'h60), 16'd5, 2, 0, 1, 0, 1, 0);
        look("R5 bit63 selects ns", 16'd5, 1, 40'h60, 0);

        cmd("R4 4K L2", mkop(0, 4'h0, 40'h40123), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R4 4K block cleared", 16'd5, 1, 40'h40000, 0);
        cmd("R4 16K", mkop(0, 4'h0, 40'h80007), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R4 16K page cleared", 16'd5, 1, 40'h80004, 0);
        cmd("R4 64K L2", mkop(0, 4'h0, 40'h11FFFF), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R4 64K block cleared", 16'd5, 1, 40'h100000, 0);

        cmd("R8 no lpa", mkop(0, 4'h0, 40'h3000000100), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R8 high bits zeroed", 16'd5, 1, 40'h3000000100, 1);
        cmd("R8 lpa", mkop(0, 4'h0, 40'h3000000100), 16'd5, 2, 1, 1, 0, 0, 1);
        look("R8 high bits compared", 16'd5, 1, 40'h3000000100, 0);

        cmd("R6 wrong level", mkop(0, 4'b0110, 40'h70), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R6 level mismatch kept", 16'd5, 1, 40'h70, 1);
        cmd("R6 wrong granule", mkop(0, 4'b1111, 40'h70), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R6 granule mismatch kept", 16'd5, 1, 40'h70, 1);
        cmd("R6 right hint", mkop(0, 4'b0111, 40'h70), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R6 matching hint cleared", 16'd5, 1, 40'h70, 0);

        cmd("R7 16K lvl1", mkop(0, 4'b1001, 40'h400), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R7 reserved as no hint", 16'd5, 1, 40'h400, 0);
        cmd("R7 lvl0", mkop(0, 4'b1100, 40'h900), 16'd5, 2, 1, 1, 0, 0, 0);
        look("R7 level 00 as no hint", 16'd5, 1, 40'h900, 0);

        cmd("R9 el0", mkop(0, 4'h0, 40'h910), 16'd5, 0, 1, 1, 0, 0, 0);
        look("R9 el0 kept", 16'd5, 1, 40'h910, 1);
        cmd("R9 el1 trap", mkop(0, 4'h0, 40'h910), 16'd5, 1, 1, 1, 1, 0, 0);
        look("R9 trap kept", 16'd5, 1, 40'h910, 1);
        cmd("R9 el1 undef", mkop(0, 4'h0, 40'h910), 16'd5, 1, 1, 1, 0, 0, 0);
        cmd("R9 el3 nop", mkop(0, 4'h0, 40'h910), 16'd5, 3, 1, 0, 0, 0, 0);
        look("R9 nop kept", 16'd5, 1, 40'h910, 1);
        cmd("R9 el3 exec", mkop(0, 4'h0, 40'h910), 16'd5, 3, 1, 1, 0, 0, 0);
        look("R9 el3 exec cleared", 16'd5, 1, 40'h910, 0);

        // collision: fill and command in the same cycle
        @(posedge clk); #1;
        fill_valid = 1; fill_vmid = 16'd7; fill_ns = 1; fill_s2only = 1; fill_last = 1;
        fill_gran = 2'd1; fill_lvl = 2'd3; fill_page = 40'hA00;
        cmd_valid = 1; cmd_op = mkop(0, 4'h0, 40'h920); cmd_vmid = 16'd5; cmd_el = 2'd2;
        cmd_nonsec = 1; el2_en = 1; nv_en = 0; sec_el2_en = 0; lpa52_en = 0;
        @(negedge clk);
        chk(cmd_ready == 0, "R11 stalled by fill", cmd_ready, 0);
        @(posedge clk); #1;
        fill_valid = 0;
        m_vld[0] = 1; m_vmid[0] = 16'd7; m_ns[0] = 1; m_s2[0] = 1; m_last[0] = 1;
        m_gran[0] = 1; m_lvl[0] = 3; m_page[0] = 40'hA00; m_ptr = 1;
        @(negedge clk);
        chk(done_o == 0, "R11 no done while stalled", done_o, 0);
        chk(cmd_ready == 1, "R11 ready after fill", cmd_ready, 1);
        @(posedge clk); #1;
        cmd_valid = 0;
        model_inval(mkop(0, 4'h0, 40'h920), 16'd5, 1, 0, 0);
        @(negedge clk);
        chk(done_o == 1, "R11 accepted after stall", done_o, 1);
        look("R11 command applied", 16'd5, 1, 40'h920, 0);
        look("R2 wrap to slot 0", 16'd7, 1, 40'hA00, 1);
        fill(16'd8, 1, 1, 1, 1, 3, 40'hB00);
        look("R2 slot 1 replaced", 16'd5, 1, 40'h20, 0);
        look("R2 new slot 1 valid", 16'd8, 1, 40'hB00, 1);

        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule